// File: doc/BRIEF.md
# Performance Counter Freeze and Interrupt Controller

This block keeps a bank of event counters and one global control word that governs them. Each counter advances by one on every clock in which its event strobe is high, unless a global freeze is in force. The controller watches two kinds of enabled condition. The first is a counter whose top bit is set while that counter's condition enable is on. The second is a chosen tap of a free-running time-base input that reads 1 while the time-base event enable is on.

When an enabled condition is present, the block acts on two control bits. If freeze-on-event is set, hardware sets the global freeze bit. If the interrupt enable is set, hardware raises a level interrupt and clears the interrupt enable in the same cycle. The interrupt stays high until software removes the condition. Software can then inspect the counters and re-arm the block.

Software reaches the control word, the condition-enable mask and the counters over a simple register bus. The bus has a write strobe, an address, write data and a privilege flag, and read data is combinational. The control word has a second, read-only alias address that either privilege level may read.

Top module: `pcnt_frz_ctrl`

## Requirements
- R1: After reset, the control word, the condition-enable mask and all counters read 0, and `irq_o` is low.
- R2: The control word uses the following bit positions, with bit 31 as the most significant. Freeze is bit 31, interrupt enable is bit 30, freeze-on-event is bit 29, the 2-bit time-base selector is bits 12:11, and the time-base event enable is bit 8. Every other bit reads 0, so writing all ones reads back 0xE0001900.
- R3: Counter k sits at address 4+k. It gains one on each clock edge where `evt_i[k]` is 1 and freeze is 0. It wraps from 0xFFFFFFFF to 0. It holds its value while freeze is 1. A bus write to a counter takes priority over an increment in the same cycle.
- R4: Counter k gives an enabled condition when its bit 31 is 1 and bit k of the condition-enable mask (address 2) is 1. With the mask bit clear, that counter gives no condition.
- R5: The time base gives an enabled condition when the time-base event enable is 1 and `tbase_i` is 1 at the tap picked by the selector: 0 picks bit 15, 1 picks bit 19, 2 picks bit 23 and 3 picks bit 31. The other taps have no effect.
- R6: While freeze-on-event is 1 and any enabled condition is present, the next clock edge sets freeze. Only a bus write clears freeze.
- R7: While the interrupt enable is 1 and any enabled condition is present, the next clock edge clears the interrupt enable and raises `irq_o`. `irq_o` stays high while the condition lasts and falls on the first edge after the condition ends. With the interrupt enable at 0, no interrupt is raised.
- R8: Hardware wins a same-cycle collision with software. A freeze set by hardware beats a bus write of 0 to freeze. An interrupt-enable clear by hardware beats a bus write of 1 to the interrupt enable.
- R9: Writes take effect only when `bus_sup` is 1; a write with `bus_sup` at 0 changes nothing. Address 1 is a read-only alias of the control word, readable at either privilege level, and writes to it are ignored. Address 0 returns the control word only when `bus_sup` is 1, and returns 0 otherwise. Reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sup | input | 1 | Supervisor privilege for this access |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| evt_i | input | NUM_CNT (4) | Per-counter event strobes |
| tbase_i | input | TB_W (32) | Free-running time-base value |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that every input is settled before the rising clock edge. They also assume that a write strobe lasts one cycle per access, since the alias and privilege checks compare the control word across a single edge. Those checks also assume no enabled condition is present during the access, because hardware may legally change the word then. The stimulus changes inputs only on the falling edge and issues one write per cycle. It checks the alias and privilege writes only while the time base and the enable mask hold all conditions off.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   localparam int REG_W    = 32;
   localparam int FRZ_BIT  = 31;
   localparam int IEN_BIT  = 30;
   localparam int FOE_BIT  = 29;
   localparam int TSEL_LO  = 11;
   localparam int TSEL_W   = 2;
   localparam int TEE_BIT  = 8;

   typedef struct packed {
      logic              frz;
      logic              ien;
      logic              foe;
      logic [TSEL_W-1:0] tsel;
      logic              tee;
   } ctl_t;

   function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
      logic [REG_W-1:0] r;
      r = '0;
      r[FRZ_BIT] = c.frz;
      r[IEN_BIT] = c.ien;
      r[FOE_BIT] = c.foe;
      r[TSEL_LO +: TSEL_W] = c.tsel;
      r[TEE_BIT] = c.tee;
      return r;
   endfunction

   function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
      ctl_t c;
      c.frz  = w[FRZ_BIT];
      c.ien  = w[IEN_BIT];
      c.foe  = w[FOE_BIT];
      c.tsel = w[TSEL_LO +: TSEL_W];
      c.tee  = w[TEE_BIT];
      return c;
   endfunction

endpackage

// File: rtl/pcnt_event_ctr.sv
module pcnt_event_ctr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (wr)
         count <= wdata;
      else if (inc)
         count <= count + W'(1);
   end

endmodule

// File: rtl/pcnt_glb_ctl.sv
module pcnt_glb_ctl
   import pcnt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  ctl_t wval,
   input  logic cond,
   output ctl_t ctl,
   output logic irq
);

   ctl_t ctl_d;
   logic hw_frz;
   logic hw_iclr;

   always_comb begin
      hw_frz  = ctl.foe & cond;
      hw_iclr = ctl.ien & cond;
      ctl_d   = ctl;
      if (wr)
         ctl_d = wval;
      // hardware actions override a same-cycle software write
      if (hw_frz)
         ctl_d.frz = 1'b1;
      if (hw_iclr)
         ctl_d.ien = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
         irq <= 1'b0;
      end else begin
         ctl <= ctl_d;
         irq <= cond & (irq | hw_iclr);
      end
   end

endmodule

// File: rtl/pcnt_frz_ctrl.sv
module pcnt_frz_ctrl
   import pcnt_pkg::*;
#(
   parameter int NUM_CNT  = 4,
   parameter int CNT_W    = 32,
   parameter int TB_W     = 32,
   parameter int ADDR_W   = 3,
   parameter int CNT_BASE = 4,
   parameter int TAP0     = 15,
   parameter int TAP1     = 19,
   parameter int TAP2     = 23,
   parameter int TAP3     = 31
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic               bus_sup,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_CNT-1:0] evt_i,
   input  logic [TB_W-1:0]    tbase_i,
   output logic               irq_o
);

   localparam int ADR_CTL   = 0;
   localparam int ADR_ALIAS = 1;
   localparam int ADR_CE    = 2;
   localparam int NUM_ADR   = 2 ** ADDR_W;
   localparam int TB_IDX_W  = $clog2(TB_W);

   // elaboration-time parameter checks
   if (CNT_BASE <= ADR_CE || CNT_BASE + NUM_CNT > NUM_ADR) begin : g_bad_map
      $error("pcnt_frz_ctrl: counters do not fit the address space");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("pcnt_frz_ctrl: CNT_W out of range");
   end
   if (NUM_CNT < 1 || NUM_CNT > REG_W) begin : g_bad_num
      $error("pcnt_frz_ctrl: NUM_CNT out of range");
   end
   if (TAP0 >= TB_W || TAP1 >= TB_W || TAP2 >= TB_W || TAP3 >= TB_W) begin : g_bad_tap
      $error("pcnt_frz_ctrl: time-base tap beyond TB_W");
   end

   logic                     sup_wr;
   logic                     ctl_wr;
   logic                     ce_wr;
   logic [NUM_CNT-1:0]       ce_q;
   logic [CNT_W-1:0]         cnt [NUM_CNT];
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;
   logic [NUM_CNT-1:0]       cnt_hit;
   logic [TB_IDX_W-1:0]      tap_idx;
   logic                     tb_hit;
   logic                     any_cond;
   ctl_t                     ctl;
   logic [REG_W-1:0]         ctl_word;

   assign sup_wr = bus_we & bus_sup;
   assign ctl_wr = sup_wr && (bus_addr == ADDR_W'(ADR_CTL));
   assign ce_wr  = sup_wr && (bus_addr == ADDR_W'(ADR_CE));

   always_ff @(posedge clk) begin
      if (!rst_n)
         ce_q <= '0;
      else if (ce_wr)
         ce_q <= bus_wdata[NUM_CNT-1:0];
   end

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic cwr;
      assign cwr = sup_wr && (bus_addr == ADDR_W'(CNT_BASE + k));
      pcnt_event_ctr #(.W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (evt_i[k] & ~ctl.frz),
         .wr    (cwr),
         .wdata (bus_wdata[CNT_W-1:0]),
         .count (cnt[k])
      );
      assign cnt_hit[k] = cnt[k][CNT_W-1] & ce_q[k];
      assign cnt_flat[k*CNT_W +: CNT_W] = cnt[k];
   end

   always_comb begin
      case (ctl.tsel)
         2'd0:    tap_idx = TB_IDX_W'(TAP0);
         2'd1:    tap_idx = TB_IDX_W'(TAP1);
         2'd2:    tap_idx = TB_IDX_W'(TAP2);
         default: tap_idx = TB_IDX_W'(TAP3);
      endcase
   end

   assign tb_hit   = tbase_i[tap_idx] & ctl.tee;
   assign any_cond = (|cnt_hit) | tb_hit;

   pcnt_glb_ctl u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wval  (ctl_unpack(bus_wdata)),
      .cond  (any_cond),
      .ctl   (ctl),
      .irq   (irq_o)
   );

   assign ctl_word = ctl_pack(ctl);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_ALIAS))
         bus_rdata = ctl_word;
      else if (bus_addr == ADDR_W'(ADR_CTL))
         bus_rdata = bus_sup ? ctl_word : '0;
      else if (bus_addr == ADDR_W'(ADR_CE))
         bus_rdata[NUM_CNT-1:0] = ce_q;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (bus_addr == ADDR_W'(CNT_BASE + k))
            bus_rdata[CNT_W-1:0] = cnt[k];
      end
   end

endmodule

// File: rtl/pcnt_frz_chk.sv
module pcnt_frz_chk #(
   parameter int ADDR_W   = 3,
   parameter int NUM_CNT  = 4,
   parameter int CNT_W    = 32,
   parameter int CNT_BASE = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_we,
   input logic                     bus_sup,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic                     wdata_frz,
   input logic                     cond,
   input logic                     frz,
   input logic                     ien,
   input logic                     foe,
   input logic                     irq,
   input logic [31:0]              ctl_word,
   input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

   logic ctl_wr;
   logic alias_wr;
   logic cnt_wr;

   assign ctl_wr   = bus_we && bus_sup && (bus_addr == ADDR_W'(0));
   assign alias_wr = bus_we && (bus_addr == ADDR_W'(1));
   assign cnt_wr   = bus_we && bus_sup && (int'(bus_addr) >= CNT_BASE)
                     && (int'(bus_addr) < CNT_BASE + NUM_CNT);

   a_r6_freeze_on_event: assert property (@(posedge clk) disable iff (!rst_n)
      foe && cond |=> frz);

   a_r6_freeze_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frz) |-> $past(ctl_wr && !wdata_frz));

   a_r7_ien_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      ien && cond |=> !ien && irq);

   a_r7_irq_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(cond));

   a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      frz && !cnt_wr |=> $stable(cnt_flat));

   a_r9_alias_ro: assert property (@(posedge clk) disable iff (!rst_n)
      alias_wr && !cond |=> $stable(ctl_word));

   a_r9_user_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !bus_sup && !cond |=> $stable(ctl_word) && $stable(cnt_flat));

endmodule

bind pcnt_frz_ctrl pcnt_frz_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_CNT  (NUM_CNT),
   .CNT_W    (CNT_W),
   .CNT_BASE (CNT_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_sup   (bus_sup),
   .bus_addr  (bus_addr),
   .wdata_frz (bus_wdata[31]),
   .cond      (any_cond),
   .frz       (ctl_word[31]),
   .ien       (ctl_word[30]),
   .foe       (ctl_word[29]),
   .irq       (irq_o),
   .ctl_word  (ctl_word),
   .cnt_flat  (cnt_flat)
);

// File: tb/pcnt_frz_ctrl_tb.sv
`timescale 1ns/1ps
module pcnt_frz_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_sup = 1'b1;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  evt_i = '0;
   logic [31:0] tbase_i = '0;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_cnt [4];

   always #2.5 clk = ~clk;

   pcnt_frz_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_sup   (bus_sup),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_i     (evt_i),
      .tbase_i   (tbase_i),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic s);
      bus_addr  = a;
      bus_wdata = d;
      bus_sup   = s;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we  = 1'b0;
      bus_sup = 1'b1;
   endtask

   task automatic rdchk(input string req, input logic [2:0] a, input logic s,
                        input logic [31:0] exp);
      bus_addr = a;
      bus_sup  = s;
      #1;
      chk(req, bus_rdata, exp);
      @(negedge clk);
      bus_sup = 1'b1;
   endtask

   function automatic int tap_of(input int s);
      return (s == 3) ? 31 : 15 + 4 * s;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      rdchk("R1 ctl", 3'd0, 1'b1, 32'd0);
      rdchk("R1 alias", 3'd1, 1'b0, 32'd0);
      rdchk("R1 mask", 3'd2, 1'b1, 32'd0);
      for (int k = 0; k < 4; k++) begin
         rdchk("R1 counter", 3'(4 + k), 1'b1, 32'd0);
         exp_cnt[k] = 32'd0;
      end

      // R2 field layout
      wr(3'd0, 32'hFFFF_FFFF, 1'b1);
      rdchk("R2 all-ones", 3'd0, 1'b1, 32'hE000_1900);
      wr(3'd0, 32'd0, 1'b1);
      rdchk("R2 cleared", 3'd0, 1'b1, 32'd0);

      // R9 privilege and alias
      wr(3'd0, 32'hFFFF_FFFF, 1'b0);
      rdchk("R9 user write ignored", 3'd0, 1'b1, 32'd0);
      wr(3'd1, 32'hFFFF_FFFF, 1'b1);
      rdchk("R9 alias write ignored", 3'd0, 1'b1, 32'd0);
      wr(3'd0, 32'h2000_0000, 1'b1);
      rdchk("R9 alias user read", 3'd1, 1'b0, 32'h2000_0000);
      rdchk("R9 alias sup read", 3'd1, 1'b1, 32'h2000_0000);
      rdchk("R9 main user read", 3'd0, 1'b0, 32'd0);
      rdchk("R9 read no side effect", 3'd0, 1'b1, 32'h2000_0000);
      wr(3'd4, 32'd55, 1'b0);
      rdchk("R9 user counter write", 3'd4, 1'b1, 32'd0);
      wr(3'd0, 32'd0, 1'b1);

      // R3 counting over every event mask
      for (int m = 1; m < 16; m++) begin
         evt_i = 4'(m);
         repeat (m % 3 + 1) @(negedge clk);
         evt_i = '0;
         for (int k = 0; k < 4; k++)
            if (m[k]) exp_cnt[k] += 32'(m % 3 + 1);
      end
      for (int k = 0; k < 4; k++)
         rdchk("R3 count", 3'(4 + k), 1'b1, exp_cnt[k]);

      wr(3'd4, 32'hFFFF_FFFF, 1'b1);
      evt_i = 4'b0001;
      @(negedge clk);
      evt_i = '0;
      exp_cnt[0] = 32'd0;
      rdchk("R3 wrap", 3'd4, 1'b1, 32'd0);

      wr(3'd0, 32'h8000_0000, 1'b1);
      evt_i = 4'hF;
      repeat (5) @(negedge clk);
      evt_i = '0;
      for (int k = 0; k < 4; k++)
         rdchk("R3 frozen", 3'(4 + k), 1'b1, exp_cnt[k]);
      wr(3'd0, 32'd0, 1'b1);

      evt_i = 4'b0010;
      wr(3'd5, 32'd100, 1'b1);
      evt_i = '0;
      rdchk("R3 write beats increment", 3'd5, 1'b1, 32'd100);

      // R5 time-base tap sweep
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 4; p++) begin
               logic fire;
               fire = (e == 1) && (p == s);
               tbase_i = 32'd1 << tap_of(p);
               wr(3'd0, 32'h4000_0000 | (32'(s) << 11) | (32'(e) << 8), 1'b1);
               @(negedge clk);
               chk("R5 tap irq", {31'd0, irq_o}, {31'd0, fire});
               rdchk("R7 ien cleared on fire", 3'd0, 1'b1,
                     (fire ? 32'd0 : 32'h4000_0000) | (32'(s) << 11) | (32'(e) << 8));
               tbase_i = '0;
               @(negedge clk);
               chk("R7 irq drops", {31'd0, irq_o}, 32'd0);
               wr(3'd0, 32'd0, 1'b1);
            end
         end
      end

      // R7 no interrupt with enable off
      tbase_i = 32'd1 << 15;
      wr(3'd0, 32'h0000_0100, 1'b1);
      repeat (2) @(negedge clk);
      chk("R7 no irq when disabled", {31'd0, irq_o}, 32'd0);
      tbase_i = '0;
      wr(3'd0, 32'd0, 1'b1);

      // R4 counter condition versus mask
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 4; j++) begin
            wr(3'(4 + k), 32'h8000_0000, 1'b1);
            wr(3'd2, 32'd1 << j, 1'b1);
            wr(3'd0, 32'h4000_0000, 1'b1);
            @(negedge clk);
            chk("R4 counter condition", {31'd0, irq_o}, {31'd0, j == k});
            wr(3'(4 + k), 32'd0, 1'b1);
            @(negedge clk);
            chk("R7 irq drops after clear", {31'd0, irq_o}, 32'd0);
            wr(3'd0, 32'd0, 1'b1);
            wr(3'd2, 32'd0, 1'b1);
         end
      end

      // R6 freeze on event
      wr(3'd4, 32'h7FFF_FFFE, 1'b1);
      wr(3'd2, 32'd1, 1'b1);
      wr(3'd0, 32'h2000_0000, 1'b1);
      evt_i = 4'b0001;
      repeat (6) @(negedge clk);
      evt_i = '0;
      rdchk("R6 counter stops one past msb", 3'd4, 1'b1, 32'h8000_0001);
      rdchk("R6 freeze set", 3'd0, 1'b1, 32'hA000_0000);
      repeat (3) @(negedge clk);
      rdchk("R6 freeze persists", 3'd0, 1'b1, 32'hA000_0000);
      wr(3'd0, 32'h2000_0000, 1'b1);
      rdchk("R8 hw set beats sw clear", 3'd0, 1'b1, 32'hA000_0000);
      wr(3'd2, 32'd0, 1'b1);
      wr(3'd0, 32'h2000_0000, 1'b1);
      rdchk("R6 sw clears freeze", 3'd0, 1'b1, 32'h2000_0000);
      wr(3'd0, 32'd0, 1'b1);
      wr(3'd4, 32'd0, 1'b1);

      // R8 interrupt-enable collision
      wr(3'd0, 32'h4000_0100, 1'b1);
      tbase_i = 32'd1 << 15;
      wr(3'd0, 32'h4000_0100, 1'b1);
      chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
      rdchk("R8 hw clear beats sw set", 3'd0, 1'b1, 32'h0000_0100);
      tbase_i = '0;
      @(negedge clk);
      wr(3'd0, 32'd0, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule